// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block reprograms the configuration registers of a single PLL whenever software or a boot controller asks for a new output frequency. A request carries a rate code. The block looks that code up in a small parameter table that supplies a pre-divider and a feedback divider. It then runs a fixed series of read-modify-write cycles on a simple internal register bus. Each cycle reads a word, replaces one field and writes the word back. While the series runs the block holds busy. When the last write completes it gives a one-cycle done pulse. A code that has no table entry gives a one-cycle error pulse and causes no bus traffic.

One instance can be parameterised as the PLL that clocks the memory bus. That instance first steers the bus-clock select field to a safe oscillator-derived source. It then reprograms the PLL and releases power-down. It waits a programmable number of reference-clock cycles for lock, and only then steers the bus clock back to the PLL divided by two. Instances that do not feed the memory bus skip both handover steps and the wait.

A separate combinational path turns a set of readback field values into an output frequency in kHz. It supports both integer and fractional feedback and flags combinations that are not valid.

Top module: `pll_reseq`

## Requirements
- R1: A request whose code matches a table entry starts a sequence using that entry's pre-divider and feedback divider. A code with no match raises err_o for exactly one cycle, causes no bus read or write, and leaves every register unchanged.
- R2: The PLL writes occur in this fixed order: power-down bit 27 set to 1, DAC power-down bit set to 1, sigma-delta power-down bit set to 1, pre-divider (bits 5:0) written, 12-bit feedback divider written at bit FB_LSB, post-divider (bits 29:28) written as 0, power-down bit 27 cleared to 0.
- R3: When MEM_BUS_PLL is 1, the first write of a sequence places code 0 (oscillator divided by two) in bits 29:24 of the bus-clock register. This write comes before any PLL register write.
- R4: Each field update is a read of an address followed in the next cycle by a write to the same address. The write changes only the bits of that field and keeps every other bit as it was read.
- R5: After the sequence, the pre-divider and feedback-divider fields hold the table values, the post-divider field holds 0, power-down holds 0, and both DAC and sigma-delta power-down bits hold 1.
- R6: When MEM_BUS_PLL is 1, at least WAIT_CYC clock cycles separate the power-down release write from the final write. The final write places code 1 (PLL divided by two) in bits 29:24 of the bus-clock register.
- R7: When MEM_BUS_PLL is 0, the sequence makes exactly the seven PLL writes, never accesses the bus-clock register, and has no lock wait.
- R8: A request that arrives while busy_o is high is ignored and does not alter the running sequence.
- R9: done_o is high for exactly one cycle after the last write. busy_o is high from the cycle after an accepted request until that pulse, and the bus is idle whenever busy_o is low.
- R10: Readback with both power-down bits at 1 (integer mode) gives FREF_KHZ × feedback / (prediv × 2^postdiv), and the fraction field is ignored.
- R11: Readback with both power-down bits at 0 (fractional mode) gives FREF_KHZ × (feedback + frac/2^24) / (prediv × 2^postdiv).
- R12: Readback with the two power-down bits unequal, or with prediv 0, sets rb_invalid_o and gives a rate of 0.
- R13: While reset is applied and directly after it, busy_o, done_o, err_o, bus_rd_o and bus_wr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Reconfiguration request, sampled when idle |
| req_code_i | input | CODE_W | Target-rate code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last write |
| err_o | output | 1 | One-cycle pulse for an unknown rate code |
| bus_rd_o | output | 1 | Register bus read strobe |
| bus_wr_o | output | 1 | Register bus write strobe |
| bus_addr_o | output | ADDR_W | Register bus word address |
| bus_wdata_o | output | 32 | Register bus write data |
| bus_rdata_i | input | 32 | Register bus read data, valid in the read cycle |
| rb_prediv_i | input | 6 | Readback pre-divider |
| rb_fbdiv_i | input | 12 | Readback feedback divider |
| rb_frac_i | input | 24 | Readback fraction |
| rb_postdiv_i | input | 2 | Readback post-divider exponent |
| rb_dacpd_i | input | 1 | Readback DAC power-down bit |
| rb_dsmpd_i | input | 1 | Readback sigma-delta power-down bit |
| rb_rate_khz_o | output | RATE_W | Computed output frequency in kHz |
| rb_invalid_o | output | 1 | Readback field combination not valid |

## Verification
Several properties are checked on every cycle: a bus read and a bus write never happen together, and each write follows a read of the same address. The bus stays quiet while the block is idle, done and err are single-cycle pulses, busy rises only after a request, and mixed power-down bits always flag invalid readback. Other behaviour can only be shown by the bench's scenarios: the exact order of writes, that bits outside each field are preserved, the length of the lock wait, the bus-clock codes, that nothing is written on a table miss, and that a request made while busy is dropped. The bench shows these by keeping a log of every bus write and comparing the final register contents against values it computes itself.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  typedef enum logic [3:0] {
    ST_BUS_SAFE = 4'd0,
    ST_PD_OFF   = 4'd1,
    ST_DAC      = 4'd2,
    ST_DSM      = 4'd3,
    ST_PREDIV   = 4'd4,
    ST_FBDIV    = 4'd5,
    ST_POST     = 4'd6,
    ST_PD_ON    = 4'd7,
    ST_BUS_PLL  = 4'd8
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_WAIT  = 2'd3
  } phase_e;

  localparam int unsigned BUS_SEL_LSB = 24;
  localparam int unsigned BUS_SEL_W   = 6;
  localparam int unsigned PD_BIT      = 27;
  localparam int unsigned POST_LSB    = 28;

  function automatic logic [31:0] field_mask(input logic [4:0] lsb, input logic [4:0] width);
    logic [31:0] ones;
    ones = (32'd1 << width) - 32'd1;
    return ones << lsb;
  endfunction

  function automatic logic [31:0] field_merge(input logic [31:0] old, input logic [4:0] lsb,
                                              input logic [4:0] width, input logic [11:0] val);
    logic [31:0] m;
    m = field_mask(lsb, width);
    return (old & ~m) | ((32'(val) << lsb) & m);
  endfunction

endpackage

// File: rtl/pll_rate_lut.sv
module pll_rate_lut #(
  parameter int unsigned CODE_W    = 16,
  parameter int unsigned NUM_RATES = 4,
  parameter logic [CODE_W-1:0] TBL_CODE [NUM_RATES] = '{16'd1066, 16'd1200, 16'd1400, 16'd1600},
  parameter logic [5:0]        TBL_PRE  [NUM_RATES] = '{6'd12, 6'd1, 6'd6, 6'd3},
  parameter logic [11:0]       TBL_FB   [NUM_RATES] = '{12'd533, 12'd50, 12'd350, 12'd200}
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o,
  output logic [5:0]        pre_o,
  output logic [11:0]       fb_o
);

  logic [NUM_RATES-1:0] match;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
    assign match[g] = (code_i == TBL_CODE[g]);
  end

  always_comb begin
    hit_o = 1'b0;
    pre_o = '0;
    fb_o  = '0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (match[i] && !hit_o) begin
        hit_o = 1'b1;
        pre_o = TBL_PRE[i];
        fb_o  = TBL_FB[i];
      end
    end
  end

endmodule

// File: rtl/pll_step_decode.sv
module pll_step_decode
  import pll_reseq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned FB_LSB    = 17,
  parameter int unsigned DACPD_BIT = 15,
  parameter int unsigned DSMPD_BIT = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 4'd2,
  parameter logic [ADDR_W-1:0] ADDR_PRE = 4'd3,
  parameter logic [ADDR_W-1:0] ADDR_FB  = 4'd1,
  parameter logic [ADDR_W-1:0] ADDR_DSM = 4'd1,
  parameter logic [ADDR_W-1:0] ADDR_BUS = 4'd4
) (
  input  step_e             step_i,
  input  logic [5:0]        pre_i,
  input  logic [11:0]       fb_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [4:0]        lsb_o,
  output logic [4:0]        width_o,
  output logic [11:0]       val_o
);

  always_comb begin
    addr_o  = ADDR_CTL;
    lsb_o   = 5'(PD_BIT);
    width_o = 5'd1;
    val_o   = 12'd0;
    unique case (step_i)
      ST_BUS_SAFE: begin addr_o = ADDR_BUS; lsb_o = 5'(BUS_SEL_LSB); width_o = 5'(BUS_SEL_W); val_o = 12'd0; end
      ST_PD_OFF:   begin addr_o = ADDR_CTL; lsb_o = 5'(PD_BIT);      width_o = 5'd1;  val_o = 12'd1; end
      ST_DAC:      begin addr_o = ADDR_DSM; lsb_o = 5'(DACPD_BIT);   width_o = 5'd1;  val_o = 12'd1; end
      ST_DSM:      begin addr_o = ADDR_DSM; lsb_o = 5'(DSMPD_BIT);   width_o = 5'd1;  val_o = 12'd1; end
      ST_PREDIV:   begin addr_o = ADDR_PRE; lsb_o = 5'd0;            width_o = 5'd6;  val_o = 12'(pre_i); end
      ST_FBDIV:    begin addr_o = ADDR_FB;  lsb_o = 5'(FB_LSB);      width_o = 5'd12; val_o = fb_i; end
      ST_POST:     begin addr_o = ADDR_CTL; lsb_o = 5'(POST_LSB);    width_o = 5'd2;  val_o = 12'd0; end
      ST_PD_ON:    begin addr_o = ADDR_CTL; lsb_o = 5'(PD_BIT);      width_o = 5'd1;  val_o = 12'd0; end
      ST_BUS_PLL:  begin addr_o = ADDR_BUS; lsb_o = 5'(BUS_SEL_LSB); width_o = 5'(BUS_SEL_W); val_o = 12'd1; end
      default:     begin addr_o = ADDR_CTL; lsb_o = 5'(PD_BIT);      width_o = 5'd1;  val_o = 12'd0; end
    endcase
  end

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int unsigned FREF_KHZ = 24000,
  parameter int unsigned RATE_W   = 32
) (
  input  logic [5:0]        prediv_i,
  input  logic [11:0]       fbdiv_i,
  input  logic [23:0]       frac_i,
  input  logic [1:0]        postdiv_i,
  input  logic              dacpd_i,
  input  logic              dsmpd_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              invalid_o
);

  logic [35:0] mult;
  logic [8:0]  den;
  logic [63:0] num;
  logic [63:0] quo;

  always_comb begin
    invalid_o = (dacpd_i != dsmpd_i) || (prediv_i == 6'd0);
    mult      = {fbdiv_i, 24'd0} + (dacpd_i ? 36'd0 : 36'(frac_i));
    den       = 9'(prediv_i) << postdiv_i;
    num       = 64'(FREF_KHZ) * 64'(mult);
    quo       = num / 64'((den == 9'd0) ? 9'd1 : den);
    rate_o    = invalid_o ? '0 : RATE_W'(quo >> 24);
  end

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
  import pll_reseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CODE_W      = 16,
  parameter int unsigned RATE_W      = 32,
  parameter int unsigned NUM_RATES   = 4,
  parameter logic [CODE_W-1:0] TBL_CODE [NUM_RATES] = '{16'd1066, 16'd1200, 16'd1400, 16'd1600},
  parameter logic [5:0]        TBL_PRE  [NUM_RATES] = '{6'd12, 6'd1, 6'd6, 6'd3},
  parameter logic [11:0]       TBL_FB   [NUM_RATES] = '{12'd533, 12'd50, 12'd350, 12'd200},
  parameter bit          MEM_BUS_PLL = 1'b1,
  parameter int unsigned FB_LSB      = 17,
  parameter int unsigned DACPD_BIT   = 15,
  parameter int unsigned DSMPD_BIT   = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 4'd2,
  parameter logic [ADDR_W-1:0] ADDR_PRE = 4'd3,
  parameter logic [ADDR_W-1:0] ADDR_FB  = 4'd1,
  parameter logic [ADDR_W-1:0] ADDR_DSM = 4'd1,
  parameter logic [ADDR_W-1:0] ADDR_BUS = 4'd4,
  parameter int unsigned WAIT_CYC    = 2400,
  parameter int unsigned FREF_KHZ    = 24000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [CODE_W-1:0] req_code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic [5:0]        rb_prediv_i,
  input  logic [11:0]       rb_fbdiv_i,
  input  logic [23:0]       rb_frac_i,
  input  logic [1:0]        rb_postdiv_i,
  input  logic              rb_dacpd_i,
  input  logic              rb_dsmpd_i,
  output logic [RATE_W-1:0] rb_rate_khz_o,
  output logic              rb_invalid_o
);

  localparam int unsigned CNT_W     = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);
  localparam step_e FIRST_STEP = MEM_BUS_PLL ? ST_BUS_SAFE : ST_PD_OFF;
  localparam step_e LAST_STEP  = MEM_BUS_PLL ? ST_BUS_PLL  : ST_PD_ON;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // state
  phase_e           phase_q, phase_d;
  step_e            step_q, step_d;
  logic [5:0]       pre_q;
  logic [11:0]      fb_q;
  logic [31:0]      rd_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             cfg_en, rd_en, cnt_en;

  logic             lut_hit;
  logic [5:0]       lut_pre;
  logic [11:0]      lut_fb;
  logic [4:0]       f_lsb, f_width;
  logic [11:0]      f_val;

  pll_rate_lut #(
    .CODE_W(CODE_W), .NUM_RATES(NUM_RATES),
    .TBL_CODE(TBL_CODE), .TBL_PRE(TBL_PRE), .TBL_FB(TBL_FB)
  ) u_lut (
    .code_i(req_code_i), .hit_o(lut_hit), .pre_o(lut_pre), .fb_o(lut_fb)
  );

  pll_step_decode #(
    .ADDR_W(ADDR_W), .FB_LSB(FB_LSB), .DACPD_BIT(DACPD_BIT), .DSMPD_BIT(DSMPD_BIT),
    .ADDR_CTL(ADDR_CTL), .ADDR_PRE(ADDR_PRE), .ADDR_FB(ADDR_FB),
    .ADDR_DSM(ADDR_DSM), .ADDR_BUS(ADDR_BUS)
  ) u_dec (
    .step_i(step_q), .pre_i(pre_q), .fb_i(fb_q),
    .addr_o(bus_addr_o), .lsb_o(f_lsb), .width_o(f_width), .val_o(f_val)
  );

  pll_rate_calc #(.FREF_KHZ(FREF_KHZ), .RATE_W(RATE_W)) u_calc (
    .prediv_i(rb_prediv_i), .fbdiv_i(rb_fbdiv_i), .frac_i(rb_frac_i),
    .postdiv_i(rb_postdiv_i), .dacpd_i(rb_dacpd_i), .dsmpd_i(rb_dsmpd_i),
    .rate_o(rb_rate_khz_o), .invalid_o(rb_invalid_o)
  );

  // next state
  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    cfg_en  = 1'b0;
    rd_en   = 1'b0;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          if (lut_hit) begin
            cfg_en  = 1'b1;
            step_d  = FIRST_STEP;
            phase_d = PH_READ;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      PH_READ: begin
        rd_en   = 1'b1;
        phase_d = PH_WRITE;
      end
      PH_WRITE: begin
        if (step_q == LAST_STEP) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else if (MEM_BUS_PLL && step_q == ST_PD_ON) begin
          phase_d = PH_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end else begin
          step_d  = step_e'(step_q + 4'd1);
          phase_d = PH_READ;
        end
      end
      PH_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          step_d  = ST_BUS_PLL;
          phase_d = PH_READ;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      phase_q <= PH_IDLE;
      step_q  <= ST_PD_OFF;
      pre_q   <= '0;
      fb_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (cfg_en) begin
        pre_q <= lut_pre;
        fb_q  <= lut_fb;
      end
      if (rd_en)  rd_q  <= bus_rdata_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign bus_rd_o    = (phase_q == PH_READ);
  assign bus_wr_o    = (phase_q == PH_WRITE);
  assign bus_wdata_o = field_merge(rd_q, f_lsb, f_width, f_val);

endmodule

// File: rtl/pll_reseq_chk.sv
module pll_reseq_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              rb_dacpd_i,
  input logic              rb_dsmpd_i,
  input logic [5:0]        rb_prediv_i,
  input logic              rb_invalid_o
);

  // R4
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));

  // R4
  rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> ($past(bus_rd_o) && $past(bus_addr_o) == bus_addr_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_rd_o && !bus_wr_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R1
  err_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i));

  // R12
  rb_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rb_dacpd_i != rb_dsmpd_i) || rb_prediv_i == 6'd0) |-> rb_invalid_o);

endmodule

bind pll_reseq pll_reseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o),
  .rb_dacpd_i(rb_dacpd_i), .rb_dsmpd_i(rb_dsmpd_i), .rb_prediv_i(rb_prediv_i),
  .rb_invalid_o(rb_invalid_o)
);

// File: tb/sim_pll_reseq.sv
module sim_pll_reseq;

  localparam int CLK_PERIOD = 10;
  localparam int WAITC      = 40;

  typedef struct packed {
    logic [15:0] code;
    logic        hit;
    logic [5:0]  pre;
    logic [11:0] fb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd1066, 1'b1, 6'd12, 12'd533},
    '{16'd1200, 1'b1, 6'd1,  12'd50},
    '{16'd1400, 1'b1, 6'd6,  12'd350},
    '{16'd1600, 1'b1, 6'd3,  12'd200},
    '{16'd999,  1'b0, 6'd0,  12'd0},
    '{16'd0,    1'b0, 6'd0,  12'd0}
  };
  localparam int ORD0 [9] = '{4, 2, 1, 1, 3, 1, 2, 2, 4};
  localparam int ORD1 [7] = '{6, 8, 8, 7, 5, 6, 6};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // u0 : memory-bus PLL
  logic        req0 = 1'b0;
  logic [15:0] code0 = '0;
  logic        busy0, done0, err0, rd0, wr0;
  logic [3:0]  addr0;
  logic [31:0] wdata0, rdata0;
  logic [5:0]  rb_pre = 6'd1;
  logic [11:0] rb_fb = 12'd1;
  logic [23:0] rb_frac = '0;
  logic [1:0]  rb_post = '0;
  logic        rb_dac = 1'b1, rb_dsm = 1'b1;
  logic [31:0] rb_rate;
  logic        rb_inv;

  // u1 : ordinary PLL
  logic        req1 = 1'b0;
  logic [15:0] code1 = '0;
  logic        busy1, done1, err1, rd1, wr1;
  logic [3:0]  addr1;
  logic [31:0] wdata1, rdata1;
  logic [31:0] rb_rate1;
  logic        rb_inv1;

  logic [31:0] mem0 [16];
  logic [31:0] mem1 [16];
  logic [3:0]  log0_addr [32];
  logic [31:0] log0_data [32];
  int          log0_cyc  [32];
  logic [3:0]  log1_addr [32];
  int          log1_cyc  [32];
  int n0 = 0, n1 = 0, ndone0 = 0, nerr0 = 0, ndone1 = 0, nerr1 = 0;

  assign rdata0 = mem0[addr0];
  assign rdata1 = mem1[addr1];

  always @(posedge clk) begin
    if (wr0) begin
      mem0[addr0] <= wdata0;
      if (n0 < 32) begin
        log0_addr[n0] <= addr0; log0_data[n0] <= wdata0; log0_cyc[n0] <= cyc;
      end
      n0 <= n0 + 1;
    end
    if (wr1) begin
      mem1[addr1] <= wdata1;
      if (n1 < 32) begin
        log1_addr[n1] <= addr1; log1_cyc[n1] <= cyc;
      end
      n1 <= n1 + 1;
    end
    if (done0) ndone0 <= ndone0 + 1;
    if (err0)  nerr0  <= nerr0 + 1;
    if (done1) ndone1 <= ndone1 + 1;
    if (err1)  nerr1  <= nerr1 + 1;
  end

  pll_reseq #(.WAIT_CYC(WAITC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req0), .req_code_i(code0),
    .busy_o(busy0), .done_o(done0), .err_o(err0),
    .bus_rd_o(rd0), .bus_wr_o(wr0), .bus_addr_o(addr0),
    .bus_wdata_o(wdata0), .bus_rdata_i(rdata0),
    .rb_prediv_i(rb_pre), .rb_fbdiv_i(rb_fb), .rb_frac_i(rb_frac),
    .rb_postdiv_i(rb_post), .rb_dacpd_i(rb_dac), .rb_dsmpd_i(rb_dsm),
    .rb_rate_khz_o(rb_rate), .rb_invalid_o(rb_inv)
  );

  pll_reseq #(
    .TBL_CODE('{16'd500, 16'd750, 16'd1000, 16'd1500}),
    .TBL_PRE('{6'd6, 6'd4, 6'd3, 6'd2}),
    .TBL_FB('{12'd125, 12'd125, 12'd125, 12'd125}),
    .MEM_BUS_PLL(1'b0), .FB_LSB(0), .DACPD_BIT(24), .DSMPD_BIT(25),
    .ADDR_CTL(4'd6), .ADDR_PRE(4'd7), .ADDR_FB(4'd5), .ADDR_DSM(4'd8),
    .ADDR_BUS(4'd4), .WAIT_CYC(WAITC)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req1), .req_code_i(code1),
    .busy_o(busy1), .done_o(done1), .err_o(err1),
    .bus_rd_o(rd1), .bus_wr_o(wr1), .bus_addr_o(addr1),
    .bus_wdata_o(wdata1), .bus_rdata_i(rdata1),
    .rb_prediv_i(6'd0), .rb_fbdiv_i(12'd0), .rb_frac_i(24'd0),
    .rb_postdiv_i(2'd0), .rb_dacpd_i(1'b0), .rb_dsmpd_i(1'b0),
    .rb_rate_khz_o(rb_rate1), .rb_invalid_o(rb_inv1)
  );

  function automatic logic [31:0] setf(input logic [31:0] w, input int lsb, input int width,
                                       input logic [31:0] v);
    logic [31:0] m;
    m = ((32'd1 << width) - 32'd1) << lsb;
    return (w & ~m) | ((v << lsb) & m);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] p);
    for (int i = 0; i < 16; i++) begin mem0[i] = p; mem1[i] = p; end
    n0 = 0; n1 = 0; ndone0 = 0; nerr0 = 0; ndone1 = 0; nerr1 = 0;
  endtask

  task automatic run0(input logic [15:0] c, input bit hit);
    int guard;
    @(negedge clk); req0 = 1'b1; code0 = c;
    @(negedge clk); req0 = 1'b0;
    if (hit) chk("R9 busy after accept", busy0, 1);
    else     chk("R1 err pulse on miss", err0, 1);
    guard = 0;
    while (busy0 && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) chk("R9 sequence ends", 0, 1);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] p;
    preload(32'hA5A5_A5A5);
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 busy in reset", busy0, 0);
    chk("R13 done in reset", done0, 0);
    chk("R13 err in reset", err0, 0);
    chk("R13 bus strobes in reset", {rd0, wr0}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 idle after reset", {busy0, done0, err0, rd0, wr0, busy1, rd1, wr1}, 0);

    // table walk on the memory-bus PLL
    for (int v = 0; v < 6; v++) begin
      p = (v % 2 == 0) ? 32'hA5A5_A5A5 : 32'h5A5A_5A5A;
      preload(p);
      run0(VECS[v].code, VECS[v].hit);
      if (VECS[v].hit) begin
        chk("R9 one done pulse", ndone0, 1);
        chk("R1 no err on hit", nerr0, 0);
        chk("R2 write count", n0, 9);
        for (int k = 0; k < 9; k++) chk("R2 R3 write order", log0_addr[k], ORD0[k]);
        chk("R3 safe bus code first", log0_data[0][29:24], 0);
        chk("R2 power-down set", log0_data[1][27], 1);
        chk("R2 power-down cleared last", log0_data[7][27], 0);
        chk("R6 lock wait length", (log0_cyc[8] - log0_cyc[7]) >= WAITC, 1);
        chk("R6 bus back to pll code", mem0[4], setf(p, 24, 6, 1));
        chk("R5 R4 ctl word", mem0[2], setf(setf(p, 27, 1, 0), 28, 2, 0));
        chk("R5 R4 prediv word", mem0[3], setf(p, 0, 6, 32'(VECS[v].pre)));
        chk("R5 R4 fb/dsm word", mem0[1],
            setf(setf(setf(p, 15, 1, 1), 16, 1, 1), 17, 12, 32'(VECS[v].fb)));
      end else begin
        chk("R1 err count", nerr0, 1);
        chk("R1 no done on miss", ndone0, 0);
        chk("R1 no writes on miss", n0, 0);
        for (int a = 1; a < 5; a++) chk("R1 registers unchanged", mem0[a], p);
      end
    end

    // R8 request during busy is dropped
    preload(32'h0);
    @(negedge clk); req0 = 1'b1; code0 = 16'd1200;
    @(negedge clk); req0 = 1'b0;
    repeat (5) @(negedge clk);
    req0 = 1'b1; code0 = 16'd1600;
    @(negedge clk); req0 = 1'b0; code0 = 16'd1066;
    while (busy0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 prediv kept from first request", mem0[3][5:0], 1);
    chk("R8 fb kept from first request", mem0[1][28:17], 50);
    chk("R8 single sequence", n0, 9);
    chk("R8 single done", ndone0, 1);

    // R7 ordinary PLL: no handover, no wait
    preload(32'hFFFF_0000);
    @(negedge clk); req1 = 1'b1; code1 = 16'd1000;
    @(negedge clk); req1 = 1'b0;
    while (busy1) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R7 write count", n1, 7);
    for (int k = 0; k < 7; k++) chk("R7 R2 write order", log1_addr[k], ORD1[k]);
    chk("R7 no wait", (log1_cyc[6] - log1_cyc[0]) < WAITC, 1);
    chk("R7 bus clock register untouched", mem1[4], 32'hFFFF_0000);
    chk("R7 done pulse", ndone1, 1);
    chk("R5 ctl word u1", mem1[6], setf(setf(32'hFFFF_0000, 27, 1, 0), 28, 2, 0));
    chk("R5 prediv u1", mem1[7], setf(32'hFFFF_0000, 0, 6, 3));
    chk("R5 fb u1 low field", mem1[5], setf(32'hFFFF_0000, 0, 12, 125));
    chk("R5 dsm u1", mem1[8], setf(setf(32'hFFFF_0000, 24, 1, 1), 25, 1, 1));

    // readback
    rb_pre = 6'd1; rb_fb = 12'd50; rb_frac = 24'd123; rb_post = 2'd0; rb_dac = 1; rb_dsm = 1;
    #1;
    chk("R10 integer rate", rb_rate, 1200000);
    chk("R10 integer valid", rb_inv, 0);
    rb_pre = 6'd3; rb_fb = 12'd200; rb_post = 2'd2;
    #1;
    chk("R10 integer with postdiv", rb_rate, 400000);
    rb_pre = 6'd2; rb_fb = 12'd50; rb_frac = 24'h80_0000; rb_post = 2'd1; rb_dac = 0; rb_dsm = 0;
    #1;
    chk("R11 fractional rate", rb_rate, 303000);
    chk("R11 fractional valid", rb_inv, 0);
    rb_dac = 1; rb_dsm = 0;
    #1;
    chk("R12 mixed invalid", {rb_inv, rb_rate}, {1'b1, 32'd0});
    rb_dac = 1; rb_dsm = 1; rb_pre = 6'd0;
    #1;
    chk("R12 zero prediv invalid", {rb_inv, rb_rate}, {1'b1, 32'd0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule